// File: doc/BRIEF.md
# SMBus Block-Transfer Data Buffer

This block is the block-data datapath of an SMBus host controller. It sits between a byte-wide register bus, used by software, and the byte-stream side of the serial bit engine. It moves the byte count and the data bytes of SMBus Block Write and Block Read transactions, with counts of 1 to 32.

There are two modes. In buffer mode, software fills or drains a 32-entry buffer through a single data port whose index advances by itself. A read of the control register sets that index back to zero. In byte-by-byte mode, only one data byte is held at a time. After each data byte, a byte-done flag stalls the bus until software services the port and writes the flag to clear it. In that mode, software asks for a NACK on the final byte of a read with a distinct last-byte command.

The register offsets the block decodes are these:
- 0: status
- 2: control
- 4: target address (bit 0 is the direction, 1 = read)
- 5: byte count
- 7: data port
- 13: auxiliary mode

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset, status (offset 0) and auxiliary (offset 13) read 0x00, and eng_active, eng_hold and eng_start are low.
- R2: In buffer mode, each write to offset 7 stores the byte at the current index and advances the index, and each read of offset 7 returns the byte at the index and advances it. The index stops at 32: writes at 32 are dropped and reads at 32 return 0x00.
- R3: Any read of the control register (offset 2) sets the buffer index back to 0.
- R4: Auxiliary bit 1 selects buffer mode (1) or byte-by-byte mode (0), and it reads back as written. All other auxiliary bits read as 0.
- R5: A control write is a start request when bit 6 is set and bits 4:2 equal 3'b101 (codes 0x54 and 0x74). When the block is idle and the count is valid, it pulses eng_start for one cycle and sets status bit 0 (busy). The first byte on the stream is the count. A block write whose count in offset 5 is 0 or above 32 sets status bit 4 (fail) and does not start.
- R6: A block write in buffer mode sends the count and then buffer entries 0 to count-1. When the last data byte is accepted, busy clears and status bit 1 (done) sets.
- R7: A block read in buffer mode places the first received byte in offset 5. The data bytes that follow go into buffer entries 0 to count-1, and done is raised as in R6.
- R8: A received count of 0 or above 32 sets fail, clears busy, and leaves done clear.
- R9: In byte-by-byte mode, every data byte sets status bit 7 (byte done). While that bit is set and busy is high, eng_hold is high and byte strobes from the engine are ignored. Writing 1 to bit 7 clears the bit.
- R10: In a byte-by-byte write, each data byte sent is the value most recently written to offset 7.
- R11: In a byte-by-byte read, offset 7 returns the latest received byte. Control bit 5 (the last-byte code 0x34) drives eng_last during the data phase.
- R12: In buffer mode, and in byte-by-byte writes, eng_last is high exactly while the final data byte is offered.
- R13: Status bits 7, 4 and 1 clear when written with 1. A start request while busy is ignored: there is no eng_start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| eng_start | output | 1 | One-cycle pulse that starts a transaction |
| eng_dir_rd | output | 1 | Direction of the transaction, 1 = read |
| eng_active | output | 1 | A transaction is in progress |
| eng_tx_data | output | 8 | Byte offered to the engine (count, then data) |
| eng_last | output | 1 | Current data byte is the final one |
| eng_hold | output | 1 | Engine must stretch the clock and wait |
| eng_byte_valid | input | 1 | Engine finished one byte on the wire |
| eng_rx_data | input | 8 | Byte received by the engine |

## Verification
The bench builds the block with its default DEPTH of 32, so random counts cover the whole legal range of 1 to 32. The same depth brings the index saturation at 32 and the out-of-range counts 0, 33 and 40 within reach. Byte-by-byte transfers use short random counts, including a count of 1, where the first data byte is also the last.

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       eng_start,
  output logic       eng_dir_rd,
  output logic       eng_active,
  output logic [7:0] eng_tx_data,
  output logic       eng_last,
  output logic       eng_hold,
  input  logic       eng_byte_valid,
  input  logic [7:0] eng_rx_data
);
  localparam int IW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [3:0] OFS_STS  = 4'd0;
  localparam logic [3:0] OFS_CTL  = 4'd2;
  localparam logic [3:0] OFS_ADR  = 4'd4;
  localparam logic [3:0] OFS_CNT  = 4'd5;
  localparam logic [3:0] OFS_PORT = 4'd7;
  localparam logic [3:0] OFS_AUX  = 4'd13;

  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] idx, xcnt;
  logic [7:0]    cnt, adr;
  logic [5:0]    ctl;
  logic          busy, in_cnt, byte_done, intr, fail, bufmode, start_q;

  function automatic logic cnt_ok(input logic [7:0] c);
    return (c != 8'd0) && (c <= 8'(DEPTH));
  endfunction

  wire [7:0] xnext    = 8'(xcnt) + 8'd1;
  wire       idx_room = idx < IW'(DEPTH);
  wire       rd_dir   = adr[0];
  wire       take     = busy && !byte_done && eng_byte_valid;
  wire       start_rq = reg_wr && reg_addr == OFS_CTL && reg_wdata[6] &&
                        reg_wdata[4:2] == 3'b101;

  assign eng_start   = start_q;
  assign eng_dir_rd  = rd_dir;
  assign eng_active  = busy;
  assign eng_hold    = busy && byte_done;
  assign eng_tx_data = in_cnt ? cnt : (bufmode ? mem[xcnt[AW-1:0]] : mem[0]);
  assign eng_last    = busy && !in_cnt &&
                       ((!bufmode && rd_dir) ? ctl[5] : (xnext == cnt));

  always_comb begin
    case (reg_addr)
      OFS_STS:  reg_rdata = {byte_done, 2'b00, fail, 2'b00, intr, busy};
      OFS_CTL:  reg_rdata = {2'b00, ctl};
      OFS_ADR:  reg_rdata = adr;
      OFS_CNT:  reg_rdata = cnt;
      OFS_PORT: reg_rdata = bufmode ? (idx_room ? mem[idx[AW-1:0]] : 8'h00) : mem[0];
      OFS_AUX:  reg_rdata = {6'b0, bufmode, 1'b0};
      default:  reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      idx <= '0; xcnt <= '0; cnt <= 8'h00; adr <= 8'h00; ctl <= 6'h00;
      busy <= 1'b0; in_cnt <= 1'b0; byte_done <= 1'b0; intr <= 1'b0;
      fail <= 1'b0; bufmode <= 1'b0; start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          OFS_STS: begin
            if (reg_wdata[7]) byte_done <= 1'b0;
            if (reg_wdata[4]) fail <= 1'b0;
            if (reg_wdata[1]) intr <= 1'b0;
          end
          OFS_CTL: ctl <= reg_wdata[5:0];
          OFS_ADR: adr <= reg_wdata;
          OFS_CNT: cnt <= reg_wdata;
          OFS_AUX: bufmode <= reg_wdata[1];
          OFS_PORT: begin
            if (!bufmode) mem[0] <= reg_wdata;
            else if (idx_room) begin
              mem[idx[AW-1:0]] <= reg_wdata;
              idx <= idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (start_rq && !busy) begin
        if (!rd_dir && !cnt_ok(cnt)) fail <= 1'b1;
        else begin
          busy <= 1'b1; in_cnt <= 1'b1; xcnt <= '0;
          byte_done <= 1'b0; start_q <= 1'b1;
        end
      end
      if (reg_rd && reg_addr == OFS_CTL) idx <= '0;
      else if (reg_rd && reg_addr == OFS_PORT && bufmode && idx_room) idx <= idx + 1'b1;
      if (take) begin
        if (in_cnt) begin
          in_cnt <= 1'b0;
          if (rd_dir) begin
            cnt <= eng_rx_data;
            if (!cnt_ok(eng_rx_data)) begin
              fail <= 1'b1;
              busy <= 1'b0;
            end
          end
        end else begin
          if (rd_dir) begin
            if (bufmode) mem[xcnt[AW-1:0]] <= eng_rx_data;
            else mem[0] <= eng_rx_data;
          end
          xcnt <= xcnt + 1'b1;
          if (!bufmode) byte_done <= 1'b1;
          if (xnext == cnt) begin
            busy <= 1'b0;
            intr <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module smbus_blkbuf_chk #(
  parameter int DEPTH = 32,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic          eng_start,
  input logic          eng_active,
  input logic          eng_hold,
  input logic          eng_byte_valid,
  input logic          byte_done,
  input logic          fail,
  input logic          intr,
  input logic [IW-1:0] idx,
  input logic [IW-1:0] xcnt
);
  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(DEPTH));
  assert_ctl_read_rewinds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_wr && reg_addr == 4'd2 |=> idx == '0);
  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_active);
  assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_active) && !fail |-> intr);
  assert_bad_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_active) && !intr |-> fail);
  assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_hold && eng_byte_valid |=> $stable(xcnt) && byte_done);
endmodule

bind smbus_blkbuf smbus_blkbuf_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .eng_start(eng_start), .eng_active(eng_active), .eng_hold(eng_hold),
  .eng_byte_valid(eng_byte_valid), .byte_done(byte_done), .fail(fail),
  .intr(intr), .idx(idx), .xcnt(xcnt)
);

// File: tb/smbus_blkbuf_tb.sv
`timescale 1ns/1ps
module smbus_blkbuf_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic eng_start, eng_dir_rd, eng_active, eng_last, eng_hold;
  logic [7:0] eng_tx_data;
  logic eng_byte_valid = 0;
  logic [7:0] eng_rx_data = 0;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] dat [33];

  always #2 clk = ~clk;

  smbus_blkbuf u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sts_exp(bit bd, bit fl, bit dn, bit bz);
    return {bd, 2'b00, fl, 2'b00, dn, bz};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wbyte(input logic [7:0] rx, output logic [7:0] tx, output logic last);
    @(negedge clk); tx = eng_tx_data; last = eng_last;
    eng_byte_valid = 1; eng_rx_data = rx;
    @(negedge clk); eng_byte_valid = 0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < 33; i++) dat[i] = 8'($urandom);
    if (n < 0) dat[0] = 0;
  endtask

  task automatic buf_write(input int n);
    logic [7:0] v, tx; logic lst;
    wr(13, 8'h02); wr(4, 8'h20); rd(2, v); wr(5, 8'(n));
    for (int i = 0; i < n; i++) wr(7, dat[i]);
    wr(2, 8'h54);
    chk(eng_start && eng_active, "R5 start pulse", {eng_start, eng_active}, 3);
    wbyte(0, tx, lst);
    chk(tx == 8'(n), "R5 count first", tx, n);
    for (int i = 0; i < n; i++) begin
      wbyte(0, tx, lst);
      chk(tx == dat[i], "R6 write data", tx, dat[i]);
      chk(lst == (i == n - 1), "R12 last flag", lst, i == n - 1);
    end
    rd(0, v);
    chk(v == sts_exp(0, 0, 1, 0), "R6 done status", v, sts_exp(0, 0, 1, 0));
    wr(0, 8'h02);
  endtask

  task automatic buf_read(input int n);
    logic [7:0] v, tx; logic lst;
    wr(13, 8'h02); wr(4, 8'h21); wr(2, 8'h54);
    wbyte(8'(n), tx, lst);
    for (int i = 0; i < n; i++) begin
      wbyte(dat[i], tx, lst);
      chk(lst == (i == n - 1), "R12 read last", lst, i == n - 1);
    end
    rd(0, v);
    chk(v == sts_exp(0, 0, 1, 0), "R7 done status", v, sts_exp(0, 0, 1, 0));
    rd(5, v);
    chk(v == 8'(n), "R7 count in data0", v, n);
    rd(2, v);
    for (int i = 0; i < n; i++) begin
      rd(7, v);
      chk(v == dat[i], "R7 buffered byte", v, dat[i]);
    end
    wr(0, 8'h02);
  endtask

  task automatic byte_write(input int n);
    logic [7:0] v, tx; logic lst;
    wr(13, 8'h00); wr(4, 8'h20); wr(5, 8'(n)); wr(7, dat[0]); wr(2, 8'h54);
    wbyte(0, tx, lst);
    chk(tx == 8'(n), "R5 count first", tx, n);
    for (int i = 0; i < n; i++) begin
      wbyte(0, tx, lst);
      chk(tx == dat[i], "R10 port byte sent", tx, dat[i]);
      chk(lst == (i == n - 1), "R12 byte-mode last", lst, i == n - 1);
      rd(0, v);
      chk(v[7] == 1'b1, "R9 byte done set", v, 8'h80);
      chk(eng_hold == (i != n - 1), "R9 hold", eng_hold, i != n - 1);
      if (i == 0 && n > 1) wbyte(0, tx, lst);
      if (i != n - 1) begin
        wr(7, dat[i + 1]); wr(0, 8'h80);
        rd(0, v);
        chk(v == sts_exp(0, 0, 0, 1), "R13 byte done cleared", v, sts_exp(0, 0, 0, 1));
      end
    end
    rd(0, v);
    chk(v == sts_exp(1, 0, 1, 0), "R9 final status", v, sts_exp(1, 0, 1, 0));
    wr(0, 8'h82);
  endtask

  task automatic byte_read(input int n);
    logic [7:0] v, tx; logic lst;
    wr(13, 8'h00); wr(4, 8'h21); wr(2, (n == 1) ? 8'h74 : 8'h54);
    wbyte(8'(n), tx, lst);
    rd(5, v);
    chk(v == 8'(n), "R11 count in data0", v, n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(eng_last == (i == n - 1), "R11 last command", eng_last, i == n - 1);
      wbyte(dat[i], tx, lst);
      rd(7, v);
      chk(v == dat[i], "R11 port byte", v, dat[i]);
      if (i == n - 2) begin
        wr(2, 8'h74);
        chk(!eng_start, "R13 start ignored busy", eng_start, 0);
      end
      if (i != n - 1) wr(0, 8'h80);
    end
    rd(0, v);
    chk(v == sts_exp(1, 0, 1, 0), "R11 final status", v, sts_exp(1, 0, 1, 0));
    wr(0, 8'h82);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, tx; logic lst;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!eng_active && !eng_hold && !eng_start, "R1 idle outputs", eng_active, 0);
    rd(0, v); chk(v == 8'h00, "R1 status reset", v, 0);
    rd(13, v); chk(v == 8'h00, "R1 aux reset", v, 0);
    wr(13, 8'hFF); rd(13, v); chk(v == 8'h02, "R4 aux readback", v, 2);
    wr(13, 8'h00); rd(13, v); chk(v == 8'h00, "R4 aux cleared", v, 0);

    fill(0);
    wr(13, 8'h02); rd(2, v);
    for (int i = 0; i < 33; i++) wr(7, dat[i]);
    rd(2, v);
    for (int i = 0; i < 32; i++) begin
      rd(7, v); chk(v == dat[i], "R2 buffer order", v, dat[i]);
    end
    rd(7, v); chk(v == 8'h00, "R2 saturated read", v, 0);
    rd(2, v); rd(7, v); rd(7, v); rd(2, v); rd(7, v);
    chk(v == dat[0], "R3 index rewound", v, dat[0]);

    wr(4, 8'h20); wr(5, 8'd0); wr(2, 8'h54);
    rd(0, v); chk(v == sts_exp(0, 1, 0, 0), "R5 zero count rejected", v, sts_exp(0, 1, 0, 0));
    wr(0, 8'h10);
    wr(5, 8'd33); wr(2, 8'h54);
    rd(0, v); chk(v == sts_exp(0, 1, 0, 0), "R5 big count rejected", v, sts_exp(0, 1, 0, 0));
    wr(0, 8'h10); rd(0, v); chk(v == 8'h00, "R13 fail cleared", v, 0);

    wr(4, 8'h21); wr(2, 8'h54); wbyte(8'd0, tx, lst);
    rd(0, v); chk(v == sts_exp(0, 1, 0, 0), "R8 zero rx count", v, sts_exp(0, 1, 0, 0));
    wr(0, 8'h10);
    wr(2, 8'h54); wbyte(8'd40, tx, lst);
    rd(0, v); chk(v == sts_exp(0, 1, 0, 0), "R8 big rx count", v, sts_exp(0, 1, 0, 0));
    wr(0, 8'h10);

    fill(0); buf_write(32);
    fill(0); buf_read(32);
    fill(0); buf_write(1);
    fill(0); buf_read(1);
    for (int k = 0; k < 12; k++) begin
      fill(0); buf_write(1 + int'($urandom % 32));
      fill(0); buf_read(1 + int'($urandom % 32));
    end
    fill(0); byte_write(1);
    fill(0); byte_read(1);
    for (int k = 0; k < 6; k++) begin
      fill(0); byte_write(2 + int'($urandom % 5));
      fill(0); byte_read(2 + int'($urandom % 5));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule